// File: doc/BRIEF.md
# Dual-Port Direct-Mapped Cache Line Array

This block is the storage of a direct-mapped cache. Each of its lines holds a group of data words, an address tag, a small attribute field and a valid flag. A primary port takes one command per accepted request: read one word, write one word, or invalidate the line. For each accepted command it returns the selected word together with the line's tag, attributes, valid flag and a hit flag. A secondary refill port writes a complete line in one clock: every word, the tag, the attributes and the valid flag.

The controller that owns this array decides what to do on a miss. It drives the refill port, and it can present a primary command on the line being refilled in that same cycle. The array forwards the incoming line, so that command sees the new contents.

The primary request and response form a valid/ready pair with a single response register. `req_ready` is high when no response is held, or when the held response is being taken in this cycle (`rsp_ready` high). A request presented while `req_ready` is low is neither executed nor recorded. A held response stays stable until `rsp_ready` takes it. The refill port has no back-pressure: every cycle with `fill_valid` high writes a line.

Top module: `dmc_cache_array`

## Requirements
- R1: The primary address is split from the least significant bit upward into three fields: the word select (the lowest log2(WORDS) bits), the line index (the next log2(LINES) bits), and the request tag (the top TAG_W bits). Each address selects exactly one line.
- R2: A command accepted at a rising edge makes `rsp_valid` high after that edge. The response carries the selected word, the line's stored tag, its attributes and its valid flag.
- R3: `rsp_hit` is high only when the line's valid flag is set and its stored tag equals the request tag.
- R4: A primary write (op 2'b01) replaces only the selected word. The other words, the tag, the attributes and the valid flag are unchanged.
- R5: An invalidate (op 2'b10) clears only the valid flag. The data words, the tag and the attributes stay readable unchanged.
- R6: A refill writes all words, the tag, the attributes and the valid flag of the line at `fill_idx` in one cycle. The valid flag takes the value of `fill_vbit`, which may be 0.
- R7: A primary command whose index equals `fill_idx` in a cycle with `fill_valid` high sees the refilled contents in its response.
- R8: When a refill and a primary write or invalidate address the same line in one cycle, the refill wins for the whole line and the primary update is dropped.
- R9: Reset clears every valid flag and `rsp_valid`. `req_ready` is high after reset.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low, all response outputs hold still, and any presented command is not executed.
- R11: The response to a write or an invalidate shows the line as it was before that command's own update. Op 2'b00 and 2'b11 are both reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Primary command present |
| req_ready | output | 1 | Primary command accepted this cycle if valid |
| req_op | input | 2 | 00 read, 01 word write, 10 invalidate, 11 read |
| req_addr | input | TAG_W+log2(LINES)+log2(WORDS) (42) | Tag, index and word select |
| req_wdata | input | WORD_W (32) | Word for a write |
| fill_valid | input | 1 | Refill the line at fill_idx this cycle |
| fill_idx | input | log2(LINES) (8) | Line index for the refill |
| fill_tag | input | TAG_W (32) | Tag written by the refill |
| fill_attr | input | ATTR_W (2) | Attributes written by the refill |
| fill_vbit | input | 1 | Valid flag written by the refill |
| fill_data | input | WORDS*WORD_W (128) | All words of the line, word 0 in the low bits |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | WORD_W (32) | Selected word |
| rsp_tag | output | TAG_W (32) | Stored tag of the line |
| rsp_attr | output | ATTR_W (2) | Stored attributes of the line |
| rsp_vbit | output | 1 | Valid flag of the line |
| rsp_hit | output | 1 | Valid and tag match |

## Verification
The bench builds the array with 16 lines of four 32-bit words, a 12-bit tag and 2-bit attributes. With the index only four bits wide, refills, invalidates and reads on distinct lines can be mixed in a short vector table. It also allows an access to an index that has never been filled, so a stale valid flag would be caught. The narrow tag makes matching and mismatching requests easy to build for the same line. Same-cycle collisions between the refill port and reads, writes and invalidates are driven explicitly, and so is a held response under back-pressure.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_INVAL = 2'b10,
    OP_ALT   = 2'b11
  } dmc_op_e;
endpackage

// File: rtl/dmc_line_store.sv
// Data, tag and attribute storage; refill has priority over a word write.
module dmc_line_store #(
  parameter int LINES  = 256,
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  parameter int TAG_W  = 32,
  parameter int ATTR_W = 2,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WSEL_W = $clog2(WORDS),
  localparam int LINE_W = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [ATTR_W-1:0] fill_attr,
  input  logic [LINE_W-1:0] fill_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WSEL_W-1:0] wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [ATTR_W-1:0] rd_attr
);
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [ATTR_W-1:0] attr_q [LINES];
  logic              clash;

  assign clash = fill_en && (fill_idx == wr_idx);

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx]  <= fill_tag;
      attr_q[fill_idx] <= fill_attr;
    end
  end

  assign rd_tag  = tag_q[rd_idx];
  assign rd_attr = attr_q[rd_idx];

  for (genvar k = 0; k < WORDS; k++) begin : g_lane
    logic [WORD_W-1:0] lane_q [LINES];
    logic              lane_we;

    assign lane_we = wr_en && !clash && (wr_sel == WSEL_W'(k));

    always_ff @(posedge clk) begin
      if (fill_en) lane_q[fill_idx] <= fill_data[k*WORD_W +: WORD_W];
      if (lane_we) lane_q[wr_idx]   <= wr_data;
    end

    assign rd_line[k*WORD_W +: WORD_W] = lane_q[rd_idx];

    AST_FILL_BEATS_WRITE: assert property (@(posedge clk) disable iff (rst)
      (wr_en && clash) |=> lane_q[$past(fill_idx)] == $past(fill_data[k*WORD_W +: WORD_W])); // R8
  end

  AST_WRITE_KEEPS_TAG: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !fill_en) |=> tag_q[$past(wr_idx)] == $past(tag_q[wr_idx])); // R4
endmodule

// File: rtl/dmc_valid_bits.sv
// Per-line valid flags; a refill in the same cycle overrides an invalidate.
module dmc_valid_bits #(
  parameter int LINES = 256,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             fill_vbit,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vbit
);
  logic [LINES-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      if (inv_en)  vld_q[inv_idx]  <= 1'b0;
      if (fill_en) vld_q[fill_idx] <= fill_vbit;
    end
  end

  assign rd_vbit = vld_q[rd_idx];

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (vld_q == '0)); // R9
  AST_INVAL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (inv_en && !(fill_en && fill_idx == inv_idx)) |=> !vld_q[$past(inv_idx)]); // R5
  AST_FILL_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> vld_q[$past(fill_idx)] == $past(fill_vbit)); // R6
endmodule

// File: rtl/dmc_resp_stage.sv
// Refill forwarding, hit compare and the response register with its handshake.
module dmc_resp_stage #(
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  parameter int TAG_W  = 32,
  parameter int ATTR_W = 2,
  localparam int WSEL_W = $clog2(WORDS),
  localparam int LINE_W = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              fwd,
  input  logic [WSEL_W-1:0] wsel,
  input  logic [TAG_W-1:0]  rtag,
  input  logic [LINE_W-1:0] st_line,
  input  logic [TAG_W-1:0]  st_tag,
  input  logic [ATTR_W-1:0] st_attr,
  input  logic              st_vbit,
  input  logic [LINE_W-1:0] f_line,
  input  logic [TAG_W-1:0]  f_tag,
  input  logic [ATTR_W-1:0] f_attr,
  input  logic              f_vbit,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [ATTR_W-1:0] rsp_attr,
  output logic              rsp_vbit,
  output logic              rsp_hit
);
  logic              acc;
  logic [LINE_W-1:0] sel_line;
  logic [TAG_W-1:0]  sel_tag;
  logic [ATTR_W-1:0] sel_attr;
  logic              sel_vbit;
  logic [WORD_W-1:0] sel_word;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;

  always_comb begin
    sel_line = fwd ? f_line : st_line;
    sel_tag  = fwd ? f_tag  : st_tag;
    sel_attr = fwd ? f_attr : st_attr;
    sel_vbit = fwd ? f_vbit : st_vbit;
    sel_word = sel_line[wsel*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_tag   <= '0;
      rsp_attr  <= '0;
      rsp_vbit  <= 1'b0;
      rsp_hit   <= 1'b0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_data  <= sel_word;
      rsp_tag   <= sel_tag;
      rsp_attr  <= sel_attr;
      rsp_vbit  <= sel_vbit;
      rsp_hit   <= sel_vbit && (sel_tag == rtag);
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_tag) && $stable(rsp_hit))); // R10
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> rsp_vbit); // R3
  AST_FWD_TAG: assert property (@(posedge clk) disable iff (rst)
    (acc && fwd) |=> (rsp_tag == $past(f_tag))); // R7
endmodule

// File: rtl/dmc_cache_array.sv
module dmc_cache_array #(
  parameter int LINES  = 256,
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  parameter int TAG_W  = 32,
  parameter int ATTR_W = 2,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WSEL_W = $clog2(WORDS),
  localparam int LINE_W = WORDS * WORD_W,
  localparam int ADDR_W = TAG_W + IDX_W + WSEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic              fill_valid,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [ATTR_W-1:0] fill_attr,
  input  logic              fill_vbit,
  input  logic [LINE_W-1:0] fill_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [ATTR_W-1:0] rsp_attr,
  output logic              rsp_vbit,
  output logic              rsp_hit
);
  import dmc_pkg::*;

  dmc_op_e           op;
  logic [WSEL_W-1:0] a_wsel;
  logic [IDX_W-1:0]  a_idx;
  logic [TAG_W-1:0]  a_tag;
  logic              acc, fwd, wr_en, inv_en;
  logic [LINE_W-1:0] st_line;
  logic [TAG_W-1:0]  st_tag;
  logic [ATTR_W-1:0] st_attr;
  logic              st_vbit;

  assign op     = dmc_op_e'(req_op);
  assign a_wsel = req_addr[WSEL_W-1:0];
  assign a_idx  = req_addr[WSEL_W +: IDX_W];
  assign a_tag  = req_addr[ADDR_W-1 -: TAG_W];

  assign acc    = req_valid && req_ready;
  assign fwd    = fill_valid && (fill_idx == a_idx);
  assign wr_en  = acc && (op == OP_WRITE);
  assign inv_en = acc && (op == OP_INVAL);

  dmc_line_store #(
    .LINES(LINES), .WORDS(WORDS), .WORD_W(WORD_W), .TAG_W(TAG_W), .ATTR_W(ATTR_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .fill_en(fill_valid), .fill_idx(fill_idx), .fill_tag(fill_tag),
    .fill_attr(fill_attr), .fill_data(fill_data),
    .wr_en(wr_en), .wr_idx(a_idx), .wr_sel(a_wsel), .wr_data(req_wdata),
    .rd_idx(a_idx), .rd_line(st_line), .rd_tag(st_tag), .rd_attr(st_attr)
  );

  dmc_valid_bits #(.LINES(LINES)) u_valid (
    .clk(clk), .rst(rst),
    .fill_en(fill_valid), .fill_idx(fill_idx), .fill_vbit(fill_vbit),
    .inv_en(inv_en), .inv_idx(a_idx),
    .rd_idx(a_idx), .rd_vbit(st_vbit)
  );

  dmc_resp_stage #(
    .WORDS(WORDS), .WORD_W(WORD_W), .TAG_W(TAG_W), .ATTR_W(ATTR_W)
  ) u_resp (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .fwd(fwd), .wsel(a_wsel), .rtag(a_tag),
    .st_line(st_line), .st_tag(st_tag), .st_attr(st_attr), .st_vbit(st_vbit),
    .f_line(fill_data), .f_tag(fill_tag), .f_attr(fill_attr), .f_vbit(fill_vbit),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_tag(rsp_tag), .rsp_attr(rsp_attr),
    .rsp_vbit(rsp_vbit), .rsp_hit(rsp_hit)
  );

  AST_ONE_CYCLE_RSP: assert property (@(posedge clk) disable iff (rst)
    acc |=> rsp_valid); // R2
endmodule

// File: tb/tb_dmc_cache_array.sv
`timescale 1ns/1ps
module tb_dmc_cache_array;
  localparam int LINES = 16, WORDS = 4, WORD_W = 32, TAG_W = 12, ATTR_W = 2;
  localparam int IDX_W = 4, WSEL_W = 2, ADDR_W = TAG_W + IDX_W + WSEL_W;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, rsp_ready = 1'b1, fill_valid = 1'b0, fill_vbit = 1'b0;
  logic req_ready, rsp_valid, rsp_vbit, rsp_hit;
  logic [1:0] req_op = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [WORD_W-1:0] req_wdata = '0, rsp_data;
  logic [IDX_W-1:0] fill_idx = '0;
  logic [TAG_W-1:0] fill_tag = '0, rsp_tag;
  logic [ATTR_W-1:0] fill_attr = '0, rsp_attr;
  logic [WORDS*WORD_W-1:0] fill_data = '0;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dmc_cache_array #(.LINES(LINES), .WORDS(WORDS), .WORD_W(WORD_W), .TAG_W(TAG_W), .ATTR_W(ATTR_W)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .fill_valid(fill_valid), .fill_idx(fill_idx),
    .fill_tag(fill_tag), .fill_attr(fill_attr), .fill_vbit(fill_vbit), .fill_data(fill_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_tag(rsp_tag),
    .rsp_attr(rsp_attr), .rsp_vbit(rsp_vbit), .rsp_hit(rsp_hit));

  typedef struct packed {
    logic [1:0] op; logic [11:0] tag; logic [3:0] idx; logic [1:0] w; logic [31:0] wd;
    logic fen; logic [3:0] fidx; logic [11:0] ftag; logic [1:0] fattr; logic fvb; logic [31:0] fseed;
    logic cd; logic [31:0] ed; logic [11:0] et; logic [1:0] ea; logic ev; logic eh;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 17;
  // op 0 read, 1 write, 2 invalidate
  localparam vec_t TBL [NV] = '{
    '{2'd0,12'h000,4'd5,2'd0,32'h0,      1'b1,4'd3,12'h0A5,2'd2,1'b1,32'h100, 1'b0,32'h0,12'h0,2'd0,1'b0,1'b0,4'd9},  // R9 never filled
    '{2'd0,12'h0A5,4'd3,2'd2,32'h0,      1'b0,4'd0,12'h0,2'd0,1'b0,32'h0, 1'b1,32'h102,12'h0A5,2'd2,1'b1,1'b1,4'd2},  // R2
    '{2'd0,12'h05A,4'd3,2'd1,32'h0,      1'b0,4'd0,12'h0,2'd0,1'b0,32'h0, 1'b1,32'h101,12'h0A5,2'd2,1'b1,1'b0,4'd3},  // R3 tag miss
    '{2'd1,12'h0A5,4'd3,2'd1,32'hDEAD0001,1'b0,4'd0,12'h0,2'd0,1'b0,32'h0, 1'b1,32'h101,12'h0A5,2'd2,1'b1,1'b1,4'd11}, // R11
    '{2'd0,12'h0A5,4'd3,2'd1,32'h0,      1'b0,4'd0,12'h0,2'd0,1'b0,32'h0, 1'b1,32'hDEAD0001,12'h0A5,2'd2,1'b1,1'b1,4'd4}, // R4
    '{2'd0,12'h0A5,4'd3,2'd0,32'h0,      1'b0,4'd0,12'h0,2'd0,1'b0,32'h0, 1'b1,32'h100,12'h0A5,2'd2,1'b1,1'b1,4'd4},  // R4
    '{2'd2,12'h0A5,4'd3,2'd0,32'h0,      1'b0,4'd0,12'h0,2'd0,1'b0,32'h0, 1'b1,32'h100,12'h0A5,2'd2,1'b1,1'b1,4'd11}, // R11
    '{2'd0,12'h0A5,4'd3,2'd1,32'h0,      1'b0,4'd0,12'h0,2'd0,1'b0,32'h0, 1'b1,32'hDEAD0001,12'h0A5,2'd2,1'b0,1'b0,4'd5}, // R5
    '{2'd0,12'h03C,4'd7,2'd3,32'h0,      1'b1,4'd7,12'h03C,2'd1,1'b1,32'h700, 1'b1,32'h703,12'h03C,2'd1,1'b1,1'b1,4'd7}, // R7
    '{2'd1,12'h044,4'd7,2'd0,32'h0000BEEF,1'b1,4'd7,12'h044,2'd3,1'b1,32'h800, 1'b1,32'h800,12'h044,2'd3,1'b1,1'b1,4'd7}, // R7
    '{2'd0,12'h044,4'd7,2'd0,32'h0,      1'b0,4'd0,12'h0,2'd0,1'b0,32'h0, 1'b1,32'h800,12'h044,2'd3,1'b1,1'b1,4'd8},  // R8
    '{2'd2,12'h044,4'd7,2'd0,32'h0,      1'b1,4'd7,12'h044,2'd0,1'b1,32'h900, 1'b1,32'h900,12'h044,2'd0,1'b1,1'b1,4'd7}, // R7
    '{2'd0,12'h044,4'd7,2'd0,32'h0,      1'b0,4'd0,12'h0,2'd0,1'b0,32'h0, 1'b1,32'h900,12'h044,2'd0,1'b1,1'b1,4'd8},  // R8
    '{2'd0,12'h0A5,4'd11,2'd2,32'h0,     1'b0,4'd0,12'h0,2'd0,1'b0,32'h0, 1'b0,32'h0,12'h0,2'd0,1'b0,1'b0,4'd1},   // R1 other index
    '{2'd0,12'h0A5,4'd3,2'd3,32'h0,      1'b0,4'd0,12'h0,2'd0,1'b0,32'h0, 1'b1,32'h103,12'h0A5,2'd2,1'b0,1'b0,4'd1},  // R1 word bits
    '{2'd0,12'h011,4'd9,2'd1,32'h0,      1'b1,4'd9,12'h011,2'd1,1'b0,32'h990, 1'b1,32'h991,12'h011,2'd1,1'b0,1'b0,4'd6}, // R6
    '{2'd0,12'h011,4'd9,2'd1,32'h0,      1'b0,4'd0,12'h0,2'd0,1'b0,32'h0, 1'b1,32'h991,12'h011,2'd1,1'b0,1'b0,4'd6}   // R6
  };

  function automatic logic [WORDS*WORD_W-1:0] mk_line(input logic [31:0] s);
    return {s + 32'd3, s + 32'd2, s + 32'd1, s};
  endfunction

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic drive_req(input logic [1:0] op, input logic [11:0] tag, input logic [3:0] idx,
                           input logic [1:0] w, input logic [31:0] wd);
    req_valid = 1'b1; req_op = op; req_addr = {tag, idx, w}; req_wdata = wd;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    @(negedge clk); rst = 1'b0;
    #1 check("R9 req_ready after reset", 64'(req_ready), 64'd1);

    for (int i = 0; i < NV; i++) begin
      string tg;
      @(negedge clk);
      drive_req(TBL[i].op, TBL[i].tag, TBL[i].idx, TBL[i].w, TBL[i].wd);
      fill_valid = TBL[i].fen; fill_idx = TBL[i].fidx; fill_tag = TBL[i].ftag;
      fill_attr = TBL[i].fattr; fill_vbit = TBL[i].fvb; fill_data = mk_line(TBL[i].fseed);
      @(posedge clk); #1;
      tg = $sformatf("R%0d vec%0d", TBL[i].rq, i);
      check({tg, " rsp_valid"}, 64'(rsp_valid), 64'd1);
      if (TBL[i].cd) begin
        check({tg, " data"}, 64'(rsp_data), 64'(TBL[i].ed));
        check({tg, " tag"}, 64'(rsp_tag), 64'(TBL[i].et));
        check({tg, " attr"}, 64'(rsp_attr), 64'(TBL[i].ea));
      end
      check({tg, " vbit"}, 64'(rsp_vbit), 64'(TBL[i].ev));
      check({tg, " hit"}, 64'(rsp_hit), 64'(TBL[i].eh));
    end

    // R10 back-pressure: refill line 2, then hold a response
    @(negedge clk);
    req_valid = 1'b0; fill_valid = 1'b1; fill_idx = 4'd2; fill_tag = 12'h222;
    fill_attr = 2'd1; fill_vbit = 1'b1; fill_data = mk_line(32'h200);
    @(negedge clk);
    fill_valid = 1'b0; rsp_ready = 1'b0;
    drive_req(2'd0, 12'h222, 4'd2, 2'd1, 32'h0);
    #1 check("R10 ready with empty response", 64'(req_ready), 64'd1);
    @(negedge clk);
    check("R10 response valid", 64'(rsp_valid), 64'd1);
    check("R10 ready low while held", 64'(req_ready), 64'd0);
    drive_req(2'd1, 12'h222, 4'd2, 2'd1, 32'h12345678);
    @(negedge clk); @(negedge clk);
    check("R10 held data", 64'(rsp_data), 64'h201);
    check("R10 held valid", 64'(rsp_valid), 64'd1);
    req_valid = 1'b0; rsp_ready = 1'b1;
    @(negedge clk);
    check("R10 response taken", 64'(rsp_valid), 64'd0);
    drive_req(2'd0, 12'h222, 4'd2, 2'd1, 32'h0);
    @(posedge clk); #1;
    check("R10 blocked write not executed", 64'(rsp_data), 64'h201);
    check("R10 hit", 64'(rsp_hit), 64'd1);

    // R9 reset clears valid flags
    @(negedge clk);
    req_valid = 1'b0; rst = 1'b1;
    @(posedge clk); #1;
    check("R9 rsp_valid cleared", 64'(rsp_valid), 64'd0);
    @(negedge clk);
    rst = 1'b0;
    drive_req(2'd0, 12'h044, 4'd7, 2'd0, 32'h0);
    @(posedge clk); #1;
    check("R9 valid flag cleared", 64'(rsp_vbit), 64'd0);
    check("R9 no hit after reset", 64'(rsp_hit), 64'd0);
    @(negedge clk); req_valid = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule